// File: doc/BRIEF.md
# Three-Share Masked Bitsliced Nibble Substitution

This block applies the 4-bit cipher substitution to sixteen nibbles at once. The nibbles are held as four 16-bit bit-planes, and every plane is split into three Boolean shares whose XOR is the secret. The substitution is computed by a fixed network of fourteen Boolean operations, built from masked gadgets, so no register ever holds an unmasked plane. The masked gadgets are share-wise XOR, NOT on share 0 alone, a three-share AND with pairwise refresh, and OR formed as NOT(AND(NOT, NOT)).

A caller presents the three shares of the four planes and pulses `start`. A sequencer then runs one gadget per clock. Each AND or OR step takes one 48-bit word of fresh randomness through a valid/ready handshake, and the step waits while that randomness is not valid. When the last step is done, `done` pulses and the three output shares hold the substituted planes. The randomness source, and the masking of the permutation and key layers, sit outside the block.

Top module: `masked_sbox3`

## Requirements
- R1: After reset `busy`, `done` and `rnd_ready` are 0 and all three output shares are zero.
- R2: Plane p carries bit p of each nibble, with plane 0 as the LSB, and lane i is bit i of every plane. Plane p sits at bits [16p+15:16p] of each share port. When `done` is 1, the XOR of `out_s0`, `out_s1` and `out_s2` in lane i equals S(n), where n is the XOR of the input shares in that lane. S maps 0..F to C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2.
- R3: The recombined result does not depend on the input masks or on the randomness values supplied.
- R4: If randomness is valid on every request, `done` is 1 in the cycle after the 15th rising edge, counting the edge that accepts `start` as the first.
- R5: `rnd_ready` is 1 only while busy on one of the four nonlinear steps. Exactly four words are consumed per evaluation. Each cycle with `rnd_ready` high and `rnd_valid` low delays `done` by one cycle.
- R6: `start` is ignored while `busy` is 1. New inputs presented then do not change the result.
- R7: `done` lasts exactly one cycle. `busy` is 0 in that cycle and stays 0 afterwards until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load input shares and begin, when idle |
| in_s0 | input | 64 | Share 0 of the four input planes |
| in_s1 | input | 64 | Share 1 of the four input planes |
| in_s2 | input | 64 | Share 2 of the four input planes |
| rnd_data | input | 48 | Fresh randomness: z01 [15:0], z02 [31:16], z12 [47:32] |
| rnd_valid | input | 1 | Randomness word is valid |
| rnd_ready | output | 1 | A nonlinear step is waiting for randomness |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle pulse: output shares are final |
| out_s0 | output | 64 | Share 0 of the four output planes |
| out_s1 | output | 64 | Share 1 of the four output planes |
| out_s2 | output | 64 | Share 2 of the four output planes |

## Verification
A wrong step in the program, or a cross term in the AND gadget that does not cancel, corrupts the recombined planes of every lane that step touches. This shows up as a wrong nibble at the `done` pulse of the same evaluation. Lanes carry all sixteen nibble values, so each evaluation exercises the whole table. A sequencer fault appears sooner and more plainly: `done` arrives in the wrong cycle, or the number of randomness handshakes is not four.

// File: rtl/masked_sbox3.sv
module masked_sbox3 #(
  parameter int W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [4*W-1:0]  in_s0,
  input  logic [4*W-1:0]  in_s1,
  input  logic [4*W-1:0]  in_s2,
  input  logic [3*W-1:0]  rnd_data,
  input  logic            rnd_valid,
  output logic            rnd_ready,
  output logic            busy,
  output logic            done,
  output logic [4*W-1:0]  out_s0,
  output logic [4*W-1:0]  out_s1,
  output logic [4*W-1:0]  out_s2
);
  localparam int NSLOT = 9;
  localparam int NSTEP = 14;

  typedef enum logic [1:0] {OP_XOR, OP_AND, OP_OR, OP_NOT} op_t;

  logic [W-1:0] v [NSLOT][3];
  logic [3:0]   pc;
  op_t          op;
  logic [3:0]   d, sa, sb;

  always_comb begin
    op = OP_XOR; d = 4'd0; sa = 4'd0; sb = 4'd0;
    case (pc)
      4'd0:  begin op = OP_XOR; d = 4'd4; sa = 4'd1; sb = 4'd2; end
      4'd1:  begin op = OP_AND; d = 4'd5; sa = 4'd2; sb = 4'd4; end
      4'd2:  begin op = OP_XOR; d = 4'd6; sa = 4'd3; sb = 4'd5; end
      4'd3:  begin op = OP_XOR; d = 4'd8; sa = 4'd0; sb = 4'd6; end
      4'd4:  begin op = OP_AND; d = 4'd5; sa = 4'd4; sb = 4'd6; end
      4'd5:  begin op = OP_XOR; d = 4'd4; sa = 4'd4; sb = 4'd8; end
      4'd6:  begin op = OP_XOR; d = 4'd5; sa = 4'd5; sb = 4'd2; end
      4'd7:  begin op = OP_OR;  d = 4'd7; sa = 4'd0; sb = 4'd5; end
      4'd8:  begin op = OP_XOR; d = 4'd1; sa = 4'd4; sb = 4'd7; end
      4'd9:  begin op = OP_NOT; d = 4'd0; sa = 4'd0; sb = 4'd0; end
      4'd10: begin op = OP_XOR; d = 4'd5; sa = 4'd5; sb = 4'd0; end
      4'd11: begin op = OP_XOR; d = 4'd3; sa = 4'd1; sb = 4'd5; end
      4'd12: begin op = OP_OR;  d = 4'd5; sa = 4'd5; sb = 4'd4; end
      4'd13: begin op = OP_XOR; d = 4'd2; sa = 4'd6; sb = 4'd5; end
      default: ;
    endcase
  end

  logic          nonlin, inv, step;
  logic [W-1:0]  a0, a1, a2, b0, b1, b2;
  logic [W-1:0]  z01, z02, z12, z10, z20, z21;
  logic [W-1:0]  g0, g1, g2, c0, c1, c2;

  assign nonlin    = (op == OP_AND) || (op == OP_OR);
  assign inv       = (op == OP_OR);
  assign rnd_ready = busy && nonlin;
  assign step      = busy && (!nonlin || rnd_valid);

  assign a0 = v[sa][0] ^ {W{inv}};
  assign a1 = v[sa][1];
  assign a2 = v[sa][2];
  assign b0 = v[sb][0] ^ {W{inv}};
  assign b1 = v[sb][1];
  assign b2 = v[sb][2];

  assign z01 = rnd_data[W-1:0];
  assign z02 = rnd_data[2*W-1:W];
  assign z12 = rnd_data[3*W-1:2*W];
  assign z10 = (z01 ^ (a0 & b1)) ^ (a1 & b0);
  assign z20 = (z02 ^ (a0 & b2)) ^ (a2 & b0);
  assign z21 = (z12 ^ (a1 & b2)) ^ (a2 & b1);
  assign g0  = (a0 & b0) ^ z01 ^ z02;
  assign g1  = (a1 & b1) ^ z10 ^ z12;
  assign g2  = (a2 & b2) ^ z20 ^ z21;

  always_comb begin
    case (op)
      OP_AND:  begin c0 = g0;       c1 = g1; c2 = g2; end
      OP_OR:   begin c0 = ~g0;      c1 = g1; c2 = g2; end
      OP_NOT:  begin c0 = ~a0;      c1 = a1; c2 = a2; end
      default: begin c0 = a0 ^ b0;  c1 = a1 ^ b1; c2 = a2 ^ b2; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      pc   <= '0;
      for (int k = 0; k < NSLOT; k++)
        for (int s = 0; s < 3; s++)
          v[k][s] <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        busy <= 1'b1;
        pc   <= '0;
        for (int k = 0; k < 4; k++) begin
          v[k][0] <= in_s0[k*W +: W];
          v[k][1] <= in_s1[k*W +: W];
          v[k][2] <= in_s2[k*W +: W];
        end
      end else if (step) begin
        v[d][0] <= c0;
        v[d][1] <= c1;
        v[d][2] <= c2;
        if (pc == 4'(NSTEP - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          pc <= pc + 4'd1;
        end
      end
    end
  end

  assign out_s0 = {v[3][0], v[2][0], v[1][0], v[8][0]};
  assign out_s1 = {v[3][1], v[2][1], v[1][1], v[8][1]};
  assign out_s2 = {v[3][2], v[2][2], v[1][2], v[8][2]};
endmodule

module masked_sbox3_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic rnd_valid,
  input logic rnd_ready,
  input logic busy,
  input logic done
);
  p_ready_needs_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_ready |-> busy);
  p_stall_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_ready && !rnd_valid) |=> (rnd_ready && busy));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_idle_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);
  p_busy_no_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
endmodule

bind masked_sbox3 masked_sbox3_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rnd_valid(rnd_valid),
  .rnd_ready(rnd_ready), .busy(busy), .done(done)
);

// File: tb/masked_sbox3_test.sv
module masked_sbox3_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] in_s0 = '0, in_s1 = '0, in_s2 = '0;
  logic [47:0] rnd_data = '0;
  logic        rnd_valid = 1'b0;
  logic        rnd_ready, busy, done;
  logic [63:0] out_s0, out_s1, out_s2;
  int total = 0;
  int failed = 0;

  always #4 clk = ~clk;

  masked_sbox3 uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_s0(in_s0), .in_s1(in_s1), .in_s2(in_s2),
    .rnd_data(rnd_data), .rnd_valid(rnd_valid), .rnd_ready(rnd_ready),
    .busy(busy), .done(done),
    .out_s0(out_s0), .out_s1(out_s1), .out_s2(out_s2)
  );

  function automatic logic [3:0] sref(input logic [3:0] n);
    case (n)
      4'h0: sref = 4'hC; 4'h1: sref = 4'h5; 4'h2: sref = 4'h6; 4'h3: sref = 4'hB;
      4'h4: sref = 4'h9; 4'h5: sref = 4'h0; 4'h6: sref = 4'hA; 4'h7: sref = 4'hD;
      4'h8: sref = 4'h3; 4'h9: sref = 4'hE; 4'hA: sref = 4'hF; 4'hB: sref = 4'h8;
      4'hC: sref = 4'h4; 4'hD: sref = 4'h7; 4'hE: sref = 4'h1; default: sref = 4'h2;
    endcase
  endfunction

  function automatic logic [63:0] expect_of(input logic [63:0] sec);
    logic [63:0] e;
    e = '0;
    for (int i = 0; i < 16; i++) begin
      logic [3:0] r;
      r = sref({sec[48+i], sec[32+i], sec[16+i], sec[i]});
      for (int p = 0; p < 4; p++) e[16*p+i] = r[p];
    end
    return e;
  endfunction

  function automatic logic [63:0] pack_lanes(input logic [3:0] base, input logic [3:0] stride);
    logic [63:0] e;
    e = '0;
    for (int i = 0; i < 16; i++) begin
      logic [3:0] n;
      n = base + stride * 4'(i);
      for (int p = 0; p < 4; p++) e[16*p+i] = n[p];
    end
    return e;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] r64();
    return {$urandom, $urandom};
  endfunction

  task automatic run(input logic [63:0] sec, input logic [63:0] m1, input logic [63:0] m2,
                     input int stall_pct, input bit poke, input string req);
    int cyc, hs, stalls;
    cyc = 0; hs = 0; stalls = 0;
    @(negedge clk);
    in_s1 = m1; in_s2 = m2; in_s0 = sec ^ m1 ^ m2;
    start = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (poke && cyc == 3) begin
        start = 1'b1;
        in_s0 = ~in_s0;
        in_s1 = r64();
      end
      if (done) break;
      if (cyc > 200) break;
      rnd_valid = ($urandom % 100) >= stall_pct;
      rnd_data  = {$urandom, $urandom};
      #1;
      if (rnd_ready && rnd_valid) hs++;
      if (rnd_ready && !rnd_valid) stalls++;
    end
    start = 1'b0;
    check({req, " R2 recombined planes"}, out_s0 ^ out_s1 ^ out_s2, expect_of(sec));
    check("R4/R5 done cycle vs stalls", 64'(cyc), 64'(15 + stalls));
    check("R5 randomness words per evaluation", 64'(hs), 64'd4);
    check("R7 busy low at done", {63'd0, busy}, 64'd0);
    @(negedge clk);
    check("R7 done single cycle", {62'd0, done, busy}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset flags", {61'd0, busy, done, rnd_ready}, 64'd0);
    check("R1 reset shares", out_s0 | out_s1 | out_s2, 64'd0);

    run(pack_lanes(4'h0, 4'h1), r64(), r64(), 0, 1'b0, "ascending");
    run(pack_lanes(4'hF, 4'hF), r64(), r64(), 0, 1'b0, "descending");
    run(pack_lanes(4'h3, 4'h7), 64'd0, 64'd0, 0, 1'b0, "R3 zero masks");
    run(pack_lanes(4'h3, 4'h7), r64(), r64(), 0, 1'b0, "R3 random masks");
    run(pack_lanes(4'h5, 4'h3), r64(), r64(), 50, 1'b0, "R5 stalls");
    run(pack_lanes(4'h9, 4'hB), r64(), r64(), 80, 1'b0, "R5 heavy stalls");
    run(pack_lanes(4'h1, 4'h5), r64(), r64(), 0, 1'b1, "R6 start while busy");
    run(pack_lanes(4'hA, 4'hD), r64(), r64(), 30, 1'b1, "R6 start while stalled");
    for (int t = 0; t < 24; t++)
      run(r64(), r64(), r64(), (t % 4) * 20, t[0], "R3 random");

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule